// File: doc/BRIEF.md
# Cipher Peripheral Status and Access-Violation Register

This block holds the read-only status word of a memory-mapped block-cipher peripheral. It receives single-cycle event strobes from the bus side: input-data write, output-data read, mode-register write, and read of a write-only register. From the cipher side it receives a manual start, a software reset, the two busy phases (data processing and sub-key generation), a completion pulse, the stream-mode selector and the ready-clear selector. From these it keeps three fields: a result-ready flag, a sticky violation flag, and the code of the most recent illegal access.

The word is returned on a combinational read port whenever the read address equals the status offset. Any other address returns zero. Reading the word has no effect on any of its bits. All strobes are sampled on the rising clock edge. Each field changes in the cycle after the edge that samples its cause.

Top module: `cipher_status_reg`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the status word reads 0x00000000.
- R2: `rd_data` returns the status word when `rd_addr` equals 0x1C, and zero for any other address. In the word, bit 0 is the ready flag, bit 8 is the violation flag and bits 15:12 are the violation code. Every other bit reads zero.
- R3: A `done_pulse` sets the ready flag. The flag is visible in the cycle after the edge that sampled the pulse.
- R4: `start_cmd` clears the ready flag. If `done_pulse` is high in the same cycle, the flag is set instead.
- R5: With `lod_sel` = 0, `out_rd` clears the ready flag and `in_wr` has no effect on it.
- R6: With `lod_sel` = 1, `in_wr` clears the ready flag and `out_rd` has no effect on it.
- R7: An illegal access sets the violation flag and loads its code. The codes are:
  - 0x0: `in_wr` while `busy_proc` is high and `smod` = 2.
  - 0x1: `out_rd` while `busy_proc` is high.
  - 0x2: `mode_wr` while `busy_proc` is high.
  - 0x3: `out_rd` while `busy_keygen` is high.
  - 0x4: `mode_wr` while `busy_keygen` is high.
  - 0x5: `wo_rd` in any phase.
- R8: An access that matches none of the R7 conditions leaves both the violation flag and the code unchanged.
- R9: The violation flag stays set until a software reset. A later violation overwrites the stored code.
- R10: `sw_reset` clears all three fields in the next cycle. It takes priority over a violation or a `done_pulse` in the same cycle.
- R11: When several R7 conditions hold in one cycle, the condition with the highest code is stored.
- R12: Repeated reads of the status word, at any address, change none of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_reset | input | 1 | Software reset command strobe |
| start_cmd | input | 1 | Manual start command strobe |
| done_pulse | input | 1 | Cipher operation completed |
| in_wr | input | 1 | Input-data register written |
| out_rd | input | 1 | Output-data register read |
| mode_wr | input | 1 | Mode register written |
| wo_rd | input | 1 | Write-only register read |
| busy_proc | input | 1 | Engine is processing data |
| busy_keygen | input | 1 | Engine is generating sub-keys |
| smod | input | 2 | Start-mode selector |
| lod_sel | input | 1 | Ready-clear selector: 0 = output read, 1 = input write |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data |

## Verification
The bench uses directed cases to isolate each rule:
- one strobe per illegal phase, which separates the six codes;
- the same strobes while idle, or with `smod` ≠ 2, which separates legal accesses from illegal ones;
- both `lod_sel` settings, each with the opposite strobe, which separates the two ready-clear sources;
- same-cycle collisions of done with start, of reset with a violation, and of several violations.

A long random phase then mixes all strobes, phases and addresses. This exposes priority or stickiness errors that only show up across sequences of events. Every read is compared against a reference model of the three fields kept in the bench.

// File: rtl/cipher_status_pkg.sv
package cipher_status_pkg;

  localparam int unsigned CODE_W   = 4;
  localparam int unsigned N_VIOL   = 6;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned READY_POS = 0;
  localparam int unsigned FLAG_POS  = 8;
  localparam int unsigned CODE_LSB  = 12;

  typedef enum logic [CODE_W-1:0] {
    VC_IN_WR_PROC    = 4'h0,
    VC_OUT_RD_PROC   = 4'h1,
    VC_MODE_WR_PROC  = 4'h2,
    VC_OUT_RD_KEYGEN = 4'h3,
    VC_MODE_WR_KEYGEN = 4'h4,
    VC_WO_RD         = 4'h5
  } viol_code_e;

  typedef struct packed {
    logic              hit;
    logic [CODE_W-1:0] code;
  } viol_t;

  // Condition vector, one bit per code value.
  function automatic logic [N_VIOL-1:0] viol_conditions(
    input logic in_wr, input logic out_rd, input logic mode_wr,
    input logic wo_rd, input logic proc, input logic keygen,
    input logic stream_match);
    logic [N_VIOL-1:0] c;
    c[VC_IN_WR_PROC]     = in_wr   & proc & stream_match;
    c[VC_OUT_RD_PROC]    = out_rd  & proc;
    c[VC_MODE_WR_PROC]   = mode_wr & proc;
    c[VC_OUT_RD_KEYGEN]  = out_rd  & keygen;
    c[VC_MODE_WR_KEYGEN] = mode_wr & keygen;
    c[VC_WO_RD]          = wo_rd;
    return c;
  endfunction

  // Highest set condition wins.
  function automatic viol_t viol_pick(input logic [N_VIOL-1:0] c);
    viol_t v;
    v.hit  = 1'b0;
    v.code = '0;
    for (int k = 0; k < N_VIOL; k++) begin
      if (c[k]) begin
        v.hit  = 1'b1;
        v.code = CODE_W'(k);
      end
    end
    return v;
  endfunction

  // Ready flag next state: reset, then set, then clear.
  function automatic logic ready_next(input logic cur, input logic swrst,
                                      input logic set, input logic clr);
    if (swrst)    return 1'b0;
    else if (set) return 1'b1;
    else if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic ready,
    input logic flag, input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] w;
    w = '0;
    w[READY_POS] = ready;
    w[FLAG_POS]  = flag;
    w[CODE_LSB +: CODE_W] = code;
    return w;
  endfunction

endpackage

// File: rtl/cipher_viol_track.sv
module cipher_viol_track
  import cipher_status_pkg::*;
#(
  parameter int unsigned MODE_W = 2,
  parameter logic [MODE_W-1:0] STREAM_MODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              in_wr,
  input  logic              out_rd,
  input  logic              mode_wr,
  input  logic              wo_rd,
  input  logic              busy_proc,
  input  logic              busy_keygen,
  input  logic [MODE_W-1:0] smod,
  output logic              flag_q,
  output logic [CODE_W-1:0] code_q
);

  logic              stream_match;
  logic [N_VIOL-1:0] cond_vec;
  viol_t             pick;
  logic              viol_hit;

  assign stream_match = (smod == STREAM_MODE);
  assign cond_vec = viol_conditions(in_wr, out_rd, mode_wr, wo_rd,
                                    busy_proc, busy_keygen, stream_match);
  assign pick     = viol_pick(cond_vec);
  assign viol_hit = pick.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (sw_reset) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (viol_hit) begin
      flag_q <= 1'b1;
      code_q <= pick.code;
    end
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_reset) |=> flag_q);

  assert_swrst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!flag_q && code_q == '0));

  assert_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol_hit && !sw_reset) |=> ($stable(flag_q) && $stable(code_q)));

  assert_wo_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wo_rd && !sw_reset) |=> (flag_q && code_q == VC_WO_RD));

endmodule

// File: rtl/cipher_ready_track.sv
module cipher_ready_track
  import cipher_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset,
  input  logic start_cmd,
  input  logic done_pulse,
  input  logic lod_sel,
  input  logic in_wr,
  input  logic out_rd,
  output logic ready_q
);

  logic rdy_clr;

  assign rdy_clr = start_cmd | (lod_sel ? in_wr : out_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_next(ready_q, sw_reset, done_pulse, rdy_clr);
  end

  assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !sw_reset) |=> ready_q);

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !done_pulse) |=> !ready_q);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_clr && !done_pulse && !sw_reset) |=> $stable(ready_q));

endmodule

// File: rtl/cipher_status_reg.sv
module cipher_status_reg
  import cipher_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h1C,
  parameter int unsigned MODE_W = 2,
  parameter logic [MODE_W-1:0] STREAM_MODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              start_cmd,
  input  logic              done_pulse,
  input  logic              in_wr,
  input  logic              out_rd,
  input  logic              mode_wr,
  input  logic              wo_rd,
  input  logic              busy_proc,
  input  logic              busy_keygen,
  input  logic [MODE_W-1:0] smod,
  input  logic              lod_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic              ready_q;
  logic              flag_q;
  logic [CODE_W-1:0] code_q;
  logic [WORD_W-1:0] status_word;
  logic              addr_hit;

  cipher_ready_track u_ready (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .start_cmd  (start_cmd),
    .done_pulse (done_pulse),
    .lod_sel    (lod_sel),
    .in_wr      (in_wr),
    .out_rd     (out_rd),
    .ready_q    (ready_q)
  );

  cipher_viol_track #(
    .MODE_W      (MODE_W),
    .STREAM_MODE (STREAM_MODE)
  ) u_viol (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .in_wr       (in_wr),
    .out_rd      (out_rd),
    .mode_wr     (mode_wr),
    .wo_rd       (wo_rd),
    .busy_proc   (busy_proc),
    .busy_keygen (busy_keygen),
    .smod        (smod),
    .flag_q      (flag_q),
    .code_q      (code_q)
  );

  assign status_word = pack_word(ready_q, flag_q, code_q);
  assign addr_hit    = (rd_addr == STATUS_OFS);

  generate
    if (DATA_W > WORD_W) begin : g_wide
      assign rd_data = addr_hit ? {{(DATA_W-WORD_W){1'b0}}, status_word} : '0;
    end else begin : g_narrow
      assign rd_data = addr_hit ? status_word[DATA_W-1:0] : '0;
    end
  endgenerate

  assert_done_beats_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && start_cmd && !sw_reset) |=> (rd_addr != STATUS_OFS || rd_data[0]));

endmodule

// File: tb/test_cipher_status_reg.sv
`timescale 1ns/1ps
module test_cipher_status_reg;

  localparam logic [7:0] OFS = 8'h1C;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_reset, start_cmd, done_pulse, in_wr, out_rd, mode_wr, wo_rd;
  logic busy_proc, busy_keygen, lod_sel;
  logic [1:0] smod;
  logic [7:0] rd_addr;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;

  logic       m_rdy;
  logic       m_flag;
  logic [3:0] m_code;

  always #5 clk = ~clk;

  cipher_status_reg i_cipher_status_reg (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .start_cmd(start_cmd),
    .done_pulse(done_pulse), .in_wr(in_wr), .out_rd(out_rd),
    .mode_wr(mode_wr), .wo_rd(wo_rd), .busy_proc(busy_proc),
    .busy_keygen(busy_keygen), .smod(smod), .lod_sel(lod_sel),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Expected word built from the layout stated in R2.
  function automatic logic [31:0] exp_word();
    return {16'h0, m_code, 3'b000, m_flag, 7'h00, m_rdy};
  endfunction

  // Expected code per the R7 table, highest code first (R11); -1 if legal.
  function automatic int b_code(input logic iw, input logic orr, input logic mw,
      input logic wr, input logic pr, input logic kg, input logic [1:0] sm);
    if (wr)                   return 5;
    if (mw && kg)             return 4;
    if (orr && kg)            return 3;
    if (mw && pr)             return 2;
    if (orr && pr)            return 1;
    if (iw && pr && sm == 2)  return 0;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sw_reset = 0; start_cmd = 0; done_pulse = 0; in_wr = 0; out_rd = 0;
    mode_wr = 0; wo_rd = 0; busy_proc = 0; busy_keygen = 0; smod = 0;
  endtask

  // Apply one cycle of inputs at a falling edge, advance the model, return at the next falling edge.
  task automatic step(input logic iw, input logic orr, input logic mw, input logic wr,
      input logic st, input logic dn, input logic sr, input logic pr, input logic kg,
      input logic [1:0] sm, input logic ld);
    int c;
    in_wr = iw; out_rd = orr; mode_wr = mw; wo_rd = wr; start_cmd = st;
    done_pulse = dn; sw_reset = sr; busy_proc = pr; busy_keygen = kg;
    smod = sm; lod_sel = ld;
    c = b_code(iw, orr, mw, wr, pr, kg, sm);
    if (sr) begin
      m_rdy = 0; m_flag = 0; m_code = 0;
    end else begin
      if (c >= 0) begin m_flag = 1; m_code = c[3:0]; end
      if (dn) m_rdy = 1;
      else if (st || (ld ? iw : orr)) m_rdy = 0;
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic idle_step();
    step(0,0,0,0,0,0,0,0,0,2'd0,lod_sel);
  endtask

  task automatic check_model(input string tag);
    rd_addr = OFS;
    #1;
    check(tag, rd_data, exp_word());
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; lod_sel = 0; rd_addr = OFS;
    idle_inputs();
    m_rdy = 0; m_flag = 0; m_code = 0;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1", rd_data, 32'h0);

    // R3: completion sets ready
    step(0,0,0,0,0,1,0,0,0,2'd0,0);
    check("R3", rd_data, 32'h0000_0001);
    // R4: start clears
    step(0,0,0,0,1,0,0,0,0,2'd0,0);
    check("R4", rd_data, 32'h0);
    // R4: done with start -> set
    step(0,0,0,0,1,1,0,0,0,2'd0,0);
    check("R4", rd_data, 32'h0000_0001);
    // R5: lod 0, input write does not clear, output read clears
    step(1,0,0,0,0,0,0,0,0,2'd0,0);
    check("R5", rd_data, 32'h0000_0001);
    step(0,1,0,0,0,0,0,0,0,2'd0,0);
    check("R5", rd_data, 32'h0);
    // R6: lod 1, output read does not clear, input write clears
    step(0,0,0,0,0,1,0,0,0,2'd0,1);
    step(0,1,0,0,0,0,0,0,0,2'd0,1);
    check("R6", rd_data, 32'h0000_0001);
    step(1,0,0,0,0,0,0,0,0,2'd0,1);
    check("R6", rd_data, 32'h0);
    lod_sel = 0;

    // R8: legal accesses leave violation fields at zero
    step(1,0,0,0,0,0,0,1,0,2'd1,0);   // input write during processing, smod != 2
    check("R8", rd_data, 32'h0);
    step(0,1,1,0,0,0,0,0,0,2'd2,0);   // idle engine
    check("R8", rd_data, 32'h0);

    // R7: each code in turn
    step(1,0,0,0,0,0,0,1,0,2'd2,0);
    check("R7", rd_data, 32'h0000_0100);
    step(0,1,0,0,0,0,0,1,0,2'd0,0);
    check("R7", rd_data, 32'h0000_1100);
    step(0,0,1,0,0,0,0,1,0,2'd0,0);
    check("R7", rd_data, 32'h0000_2100);
    step(0,1,0,0,0,0,0,0,1,2'd0,0);
    check("R7", rd_data, 32'h0000_3100);
    step(0,0,1,0,0,0,0,0,1,2'd0,0);
    check("R7", rd_data, 32'h0000_4100);
    step(0,0,0,1,0,0,0,0,0,2'd0,0);
    check("R7", rd_data, 32'h0000_5100);

    // R9: older code overwritten, flag kept; legal access keeps code
    step(0,1,0,0,0,0,0,1,0,2'd0,0);
    check("R9", rd_data, 32'h0000_1100);
    step(0,1,0,0,0,0,0,0,0,2'd0,0);
    check("R9", rd_data, 32'h0000_1100);

    // R12: repeated reads, including other addresses, change nothing
    for (int i = 0; i < 3; i++) begin
      rd_addr = 8'h18; #1;
      idle_step();
      check_model("R12");
    end

    // R2: other addresses read zero
    rd_addr = 8'h18; #1;
    check("R2", rd_data, 32'h0);
    rd_addr = 8'h1D; #1;
    check("R2", rd_data, 32'h0);
    rd_addr = OFS;

    // R11: several violations in one cycle
    step(1,1,1,0,0,0,0,1,1,2'd2,0);
    check("R11", rd_data, 32'h0000_4100);
    step(1,1,0,0,0,0,0,1,0,2'd2,0);
    check("R11", rd_data, 32'h0000_1100);

    // R10: reset wins over violation and done
    step(0,0,0,1,0,1,1,0,0,2'd0,0);
    check("R10", rd_data, 32'h0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] e;
      step(($urandom%4)==0, ($urandom%4)==0, ($urandom%5)==0, ($urandom%9)==0,
           ($urandom%8)==0, ($urandom%6)==0, ($urandom%30)==0,
           ($urandom%2)==0, ($urandom%3)==0, 2'($urandom%4), 1'($urandom%2));
      a = (($urandom%4)==0) ? 8'($urandom) : OFS;
      rd_addr = a; #1;
      e = (a == OFS) ? exp_word() : 32'h0;
      check("R2", rd_data, e);
      rd_addr = OFS; #1;
      check("R3", {31'h0, rd_data[0]}, {31'h0, m_rdy});
      check("R9", {31'h0, rd_data[8]}, {31'h0, m_flag});
      check("R7", {28'h0, rd_data[15:12]}, {28'h0, m_code});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule